// File: doc/BRIEF.md
# Warp Predicate Vote Unit

This block computes a warp-wide collective from one Boolean predicate per lane. Each lane supplies its predicate, and an active-lane mask selects which lanes take part. An operation code picks one of four reductions. Three of them yield a single flag that is copied to every lane: whether some active lane is true, whether every active lane is true, and whether all active lanes agree. The fourth yields a bit vector with one bit per lane.

A request is accepted whenever the valid input is high, and a new request may be issued every cycle. The reduction runs through a tree of fixed latency. A parameter sets the latency to one or two cycles. With two cycles, a register sits between the per-group partial reductions and the final combine. The warp width is a parameter and is normally 8 or 32 lanes.

Top module: `warp_vote_unit`

## Requirements
- R1: With op code 0 (any), the scalar result is 1 exactly when at least one lane with its mask bit set has its predicate set.
- R2: With op code 1 (all), the scalar result is 1 exactly when no lane with its mask bit set has its predicate clear.
- R3: With op code 2 (uniform), the scalar result is 1 exactly when the active lanes do not hold both a 1 and a 0.
- R4: With op code 3 (ballot), bit i of the ballot output equals lane i's predicate ANDed with lane i's mask bit, so bits of inactive lanes are 0.
- R5: With an all-zero mask, the results are as follows: any gives 0, all gives 1, uniform gives 1, and ballot gives an all-zero vector. Predicates of masked-off lanes never change any result.
- R6: The scalar result is broadcast, so every bit of the per-lane result output carries the same value.
- R7: The output valid equals the input valid delayed by exactly LATENCY clock cycles (1 or 2), and results appear in that same cycle.
- R8: While reset is asserted, the output valid, the per-lane result and the ballot output are all 0.
- R9: In ballot mode the per-lane result is all zeros. In the three scalar modes the ballot output is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Request valid |
| op_i | input | 2 | Operation: 0 any, 1 all, 2 uniform, 3 ballot |
| pred_i | input | LANES | Per-lane predicate |
| mask_i | input | LANES | Per-lane active mask |
| out_valid_o | output | 1 | Result valid, LATENCY cycles after the request |
| result_o | output | LANES | Scalar result copied to every lane |
| ballot_o | output | LANES | Masked predicate vector in ballot mode |

## Verification
The bench goes after the empty mask, a full mask with every predicate equal, and single-lane masks. A design that reduced without the mask would let idle lanes flip any and all. A design that defaulted to the wrong identity would report all or uniform as 0 on an empty warp. It also sets predicates on masked-off lanes in ballot mode: leaking them shows up as stray ballot bits. Finally, it issues back-to-back and isolated requests, which exposes an off-by-one pipeline depth as a valid pulse in the wrong cycle.

// File: rtl/vote_pkg.sv
package vote_pkg;

    typedef enum logic [1:0] {
        VOTE_ANY    = 2'd0,
        VOTE_ALL    = 2'd1,
        VOTE_UNI    = 2'd2,
        VOTE_BALLOT = 2'd3
    } vote_op_e;

endpackage

// File: rtl/vote_group_reduce.sv
// First tree level: each group of GROUP lanes yields a "some active lane true"
// flag and a "some active lane false" flag, plus the masked ballot bits.
module vote_group_reduce #(
    parameter int LANES = 32,
    parameter int GROUP = 4,
    localparam int NGROUPS = LANES / GROUP
) (
    input  logic [LANES-1:0]   pred_i,
    input  logic [LANES-1:0]   mask_i,
    output logic [NGROUPS-1:0] hit_o,
    output logic [NGROUPS-1:0] miss_o,
    output logic [LANES-1:0]   ballot_o
);

    logic [LANES-1:0] true_act;
    logic [LANES-1:0] false_act;

    assign true_act  = pred_i & mask_i;
    assign false_act = ~pred_i & mask_i;
    assign ballot_o  = true_act;

    for (genvar g = 0; g < NGROUPS; g++) begin : g_grp
        assign hit_o[g]  = |true_act[g*GROUP +: GROUP];
        assign miss_o[g] = |false_act[g*GROUP +: GROUP];
    end

endmodule

// File: rtl/vote_combine.sv
// Final tree level: folds group flags and selects the result for the op.
module vote_combine
    import vote_pkg::*;
#(
    parameter int LANES   = 32,
    parameter int NGROUPS = 8
) (
    input  vote_op_e           op_i,
    input  logic [NGROUPS-1:0] hit_i,
    input  logic [NGROUPS-1:0] miss_i,
    input  logic [LANES-1:0]   ballot_i,
    output logic               scalar_o,
    output logic [LANES-1:0]   ballot_o
);

    logic some_true;
    logic some_false;

    assign some_true  = |hit_i;
    assign some_false = |miss_i;

    always_comb begin
        scalar_o = 1'b0;
        ballot_o = '0;
        unique case (op_i)
            VOTE_ANY:    scalar_o = some_true;
            VOTE_ALL:    scalar_o = !some_false;
            VOTE_UNI:    scalar_o = !(some_true && some_false);
            VOTE_BALLOT: ballot_o = ballot_i;
            default:     scalar_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/warp_vote_unit.sv
module warp_vote_unit
    import vote_pkg::*;
#(
    parameter int LANES   = 32,
    parameter int LATENCY = 2,
    parameter int GROUP   = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             in_valid_i,
    input  logic [1:0]       op_i,
    input  logic [LANES-1:0] pred_i,
    input  logic [LANES-1:0] mask_i,
    output logic             out_valid_o,
    output logic [LANES-1:0] result_o,
    output logic [LANES-1:0] ballot_o
);

    localparam int NGROUPS = LANES / GROUP;

    typedef struct packed {
        logic               valid;
        vote_op_e           op;
        logic [NGROUPS-1:0] hit;
        logic [NGROUPS-1:0] miss;
        logic [LANES-1:0]   bal;
    } mid_t;

    typedef struct packed {
        logic             valid;
        logic             scalar;
        logic [LANES-1:0] ballot;
    } out_t;

    initial begin
        if (!(LATENCY == 1 || LATENCY == 2)) $error("LATENCY must be 1 or 2");
        if (LANES % GROUP != 0) $error("LANES must be a multiple of GROUP");
    end

    logic [NGROUPS-1:0] grp_hit;
    logic [NGROUPS-1:0] grp_miss;
    logic [LANES-1:0]   grp_bal;

    vote_group_reduce #(.LANES(LANES), .GROUP(GROUP)) u_grp (
        .pred_i   (pred_i),
        .mask_i   (mask_i),
        .hit_o    (grp_hit),
        .miss_o   (grp_miss),
        .ballot_o (grp_bal)
    );

    mid_t mid_d;
    mid_t mid_s;

    always_comb begin
        mid_d       = '0;
        mid_d.valid = in_valid_i;
        mid_d.op    = vote_op_e'(op_i);
        mid_d.hit   = grp_hit;
        mid_d.miss  = grp_miss;
        mid_d.bal   = grp_bal;
    end

    if (LATENCY == 2) begin : g_two_stage
        mid_t mid_q;
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) mid_q <= '0;
            else         mid_q <= mid_d;
        end
        assign mid_s = mid_q;
    end else begin : g_one_stage
        assign mid_s = mid_d;
    end

    logic             cmb_scalar;
    logic [LANES-1:0] cmb_ballot;

    vote_combine #(.LANES(LANES), .NGROUPS(NGROUPS)) u_cmb (
        .op_i     (mid_s.op),
        .hit_i    (mid_s.hit),
        .miss_i   (mid_s.miss),
        .ballot_i (mid_s.bal),
        .scalar_o (cmb_scalar),
        .ballot_o (cmb_ballot)
    );

    out_t out_d;
    out_t out_q;

    always_comb begin
        out_d        = '0;
        out_d.valid  = mid_s.valid;
        out_d.scalar = cmb_scalar;
        out_d.ballot = cmb_ballot;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) out_q <= '0;
        else         out_q <= out_d;
    end

    assign out_valid_o = out_q.valid;
    assign result_o    = {LANES{out_q.scalar}};
    assign ballot_o    = out_q.ballot;

    // ------------------------------------------------------------------
    // Assertions
    // ------------------------------------------------------------------
    logic [1:0] warm_d;
    logic [1:0] warm_q;

    always_comb warm_d = (warm_q == 2'd3) ? warm_q : warm_q + 2'd1;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) warm_q <= '0;
        else         warm_q <= warm_d;
    end

    p_valid_delay_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (warm_q >= 2'(LATENCY)) |-> (out_valid_o == $past(in_valid_i, LATENCY)));

    p_ballot_masked_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (warm_q >= 2'(LATENCY)) |-> ((ballot_o & ~$past(mask_i, LATENCY)) == '0));

    p_empty_any_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((warm_q >= 2'(LATENCY)) && $past(mask_i, LATENCY) == '0
         && $past(op_i, LATENCY) == 2'd0) |-> (result_o == '0));

    p_broadcast_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (result_o == '0) || (result_o == '1));

    p_mode_exclusive_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !((|result_o) && (|ballot_o)));

    p_reset_quiet_r8: assert property (@(posedge clk_i)
        !rst_ni |-> (!out_valid_o && result_o == '0 && ballot_o == '0));

endmodule

// File: tb/test_warp_vote_unit.sv
`timescale 1ns/1ps
module test_warp_vote_unit;

    localparam int LANES   = 32;
    localparam int LATENCY = 2;

    logic             clk_i = 1'b0;
    logic             rst_ni = 1'b0;
    logic             in_valid_i = 1'b0;
    logic [1:0]       op_i = '0;
    logic [LANES-1:0] pred_i = '0;
    logic [LANES-1:0] mask_i = '0;
    logic             out_valid_o;
    logic [LANES-1:0] result_o;
    logic [LANES-1:0] ballot_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk_i = ~clk_i;

    warp_vote_unit #(.LANES(LANES), .LATENCY(LATENCY)) i_warp_vote_unit (
        .clk_i, .rst_ni, .in_valid_i, .op_i, .pred_i, .mask_i,
        .out_valid_o, .result_o, .ballot_o
    );

    function automatic logic [LANES-1:0] exp_result(logic [1:0] op,
                                                    logic [LANES-1:0] p,
                                                    logic [LANES-1:0] m);
        logic t, f, s;
        t = |(p & m);
        f = |(~p & m);
        case (op)
            2'd0:    s = t;
            2'd1:    s = !f;
            2'd2:    s = !(t && f);
            default: s = 1'b0;
        endcase
        return {LANES{s}};
    endfunction

    function automatic logic [LANES-1:0] exp_ballot(logic [1:0] op,
                                                    logic [LANES-1:0] p,
                                                    logic [LANES-1:0] m);
        return (op == 2'd3) ? (p & m) : '0;
    endfunction

    task automatic check(bit ok, string tag, logic [LANES-1:0] act, logic [LANES-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    string tags [4] = '{"R1 any", "R2 all", "R3 uni", "R4 ballot"};

    // Issue one isolated request and check the result LATENCY cycles later (R7).
    task automatic run_op(logic [1:0] op, logic [LANES-1:0] p, logic [LANES-1:0] m, string extra);
        logic [LANES-1:0] er, eb;
        er = exp_result(op, p, m);
        eb = exp_ballot(op, p, m);
        @(negedge clk_i);
        in_valid_i = 1'b1; op_i = op; pred_i = p; mask_i = m;
        @(negedge clk_i);
        in_valid_i = 1'b0; pred_i = ~p;
        for (int k = 1; k < LATENCY; k++) begin
            check(out_valid_o == 1'b0, "R7 early valid", LANES'(out_valid_o), '0);
            @(negedge clk_i);
        end
        check(out_valid_o == 1'b1, "R7 valid", LANES'(out_valid_o), LANES'(1));
        check(result_o == er, {tags[op], extra, " R6 R9 result"}, result_o, er);
        check(ballot_o == eb, {tags[op], extra, " R9 ballot"}, ballot_o, eb);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        // R8: outputs quiet during reset, even with a request presented
        in_valid_i = 1'b1; op_i = 2'd0; pred_i = '1; mask_i = '1;
        repeat (3) @(negedge clk_i);
        check(out_valid_o == 1'b0, "R8 valid in reset", LANES'(out_valid_o), '0);
        check(result_o == '0, "R8 result in reset", result_o, '0);
        check(ballot_o == '0, "R8 ballot in reset", ballot_o, '0);
        in_valid_i = 1'b0;
        rst_ni = 1'b1;
        repeat (2) @(negedge clk_i);
        check(out_valid_o == 1'b0, "R7 idle after reset", LANES'(out_valid_o), '0);

        // R5: empty mask with garbage predicates
        for (int op = 0; op < 4; op++) run_op(2'(op), 32'hDEAD_BEEF, '0, " R5 empty");
        // full mask, uniform predicates
        for (int op = 0; op < 4; op++) run_op(2'(op), '1, '1, " full ones");
        for (int op = 0; op < 4; op++) run_op(2'(op), '0, '1, " full zeros");
        // single active lane at edges; idle lanes disagree (R5)
        for (int op = 0; op < 4; op++) run_op(2'(op), 32'h0000_0001, 32'h0000_0001, " R5 lane0");
        for (int op = 0; op < 4; op++) run_op(2'(op), 32'h7FFF_FFFF, 32'h8000_0000, " R5 lane31");
        // R4: inactive lanes with set predicates must not show up
        run_op(2'd3, 32'hFFFF_0000, 32'h0F0F_0F0F, " R4 mask");

        // Random isolated requests
        for (int i = 0; i < 300; i++) begin
            logic [LANES-1:0] m, p;
            m = $urandom();
            if ($urandom_range(0, 3) == 0) m = m & $urandom() & $urandom();
            case ($urandom_range(0, 3))
                0: p = m;
                1: p = ~m;
                default: p = $urandom();
            endcase
            run_op(2'($urandom_range(0, 3)), p, m, " random");
        end

        // R7: back-to-back stream, compare each output LATENCY cycles later
        begin
            logic [1:0]       qop [64];
            logic [LANES-1:0] qp  [64];
            logic [LANES-1:0] qm  [64];
            logic             qv  [64];
            for (int i = 0; i < 64; i++) begin
                qop[i] = 2'($urandom_range(0, 3));
                qp[i]  = $urandom();
                qm[i]  = $urandom();
                qv[i]  = ($urandom_range(0, 4) != 0);
            end
            for (int c = 0; c < 64 + LATENCY; c++) begin
                @(negedge clk_i);
                if (c >= LATENCY) begin
                    int j;
                    j = c - LATENCY;
                    check(out_valid_o == qv[j], "R7 stream valid", LANES'(out_valid_o), LANES'(qv[j]));
                    if (qv[j]) begin
                        check(result_o == exp_result(qop[j], qp[j], qm[j]),
                              "R1 R2 R3 stream result", result_o, exp_result(qop[j], qp[j], qm[j]));
                        check(ballot_o == exp_ballot(qop[j], qp[j], qm[j]),
                              "R4 stream ballot", ballot_o, exp_ballot(qop[j], qp[j], qm[j]));
                    end
                end
                if (c < 64) begin
                    in_valid_i = qv[c]; op_i = qop[c]; pred_i = qp[c]; mask_i = qm[c];
                end else begin
                    in_valid_i = 1'b0;
                end
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule